// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This unit watches one bit of a peripheral port (the most significant bit of port A) for an edge of a chosen direction. When that edge is seen it latches a pin-event flag, and when the pin interrupt is enabled it drives a shared active-low interrupt request. The flag sits next to the interval timer's timeout flag in one status byte, and the request line is shared by both sources.

The host bus decoder hands the unit two strobes. One is a control write. The other is a status read. The decoder also passes the two lowest address bits. On a control write, the edge direction and the pin interrupt enable come from those address bits, so no data is needed. A status read returns the status byte on a registered read-data port and acknowledges the pin event. The timer block supplies its own flag and enable as levels. The pin is asynchronous and is synchronised inside the unit.

Top module: `pin_edge_irq`

## Requirements
- R1: A synchronous reset leaves `irq_n` high, `rd_data` at 0x00, the pin interrupt disabled and the edge direction set to falling.
- R2: On a cycle with `ctl_wr` high, `ctl_addr[0]` sets the edge direction (1 = rising, 0 = falling) and `ctl_addr[1]` sets the pin interrupt enable (1 = enabled). The new settings apply from the next cycle.
- R3: The pin-event flag is set only by an edge in the selected direction. An edge in the other direction leaves it clear.
- R4: The pin-event flag is set whether or not the pin interrupt is enabled. While the pin interrupt is disabled, the pin-event flag does not pull `irq_n` low.
- R5: With the pin interrupt enabled, `irq_n` goes low on the fourth rising clock edge after the pin changes. That is two synchroniser stages, one edge-compare stage and one output register.
- R6: When `flag_rd` is high at a clock edge, `rd_data` is loaded on that edge. Bit 7 holds the timer flag, bit 6 holds the pin-event flag, and bits 5..0 are 0. Between reads, `rd_data` holds its value.
- R7: A status read clears the pin-event flag, and `irq_n` releases one cycle after that. The read does not change the timer flag.
- R8: If a pin edge is detected in the same cycle as a status read, the read returns the old flag value and the pin-event flag ends up set.
- R9: When `tmr_flag` and `tmr_en` are both high, `irq_n` goes low one cycle later. When `tmr_en` is low, the timer flag does not drive `irq_n`.
- R10: For SYNC_STAGES+1 cycles after reset, no pin edge is reported. A pin held high through reset therefore does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous port bit that is watched |
| ctl_wr | input | 1 | Decoded control-write strobe |
| ctl_addr | input | 2 | Address bits: [0] edge direction, [1] pin interrupt enable |
| flag_rd | input | 1 | Decoded status-read strobe |
| tmr_flag | input | 1 | Timeout flag level from the timer block |
| tmr_en | input | 1 | Timer interrupt enable from the timer block |
| rd_data | output | FLAG_W | Registered status byte |
| irq_n | output | 1 | Shared interrupt request, active low |

## Verification
On every cycle, assertions check four things. Each control write must be latched. A detected edge must set the flag, even against a same-cycle read. A read must clear the flag and return the value it had before the read. The request line must follow the enabled timer source, and it must stay high when no source is enabled. Only the bench's scenarios can show behaviour that spans several stages. Those are the exact four-edge pin-to-request latency, the rejection of the opposite edge, the quiet period after reset with the pin held high, and the ordering when an edge and a read land on the same edge.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_ctl.sv
module irq_edge_ctl
  import pin_edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_addr,
  output edge_pol_t  pol,
  output logic       pin_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pol    <= POL_FALL;
      pin_en <= 1'b0;
    end else if (ctl_wr) begin
      pol    <= edge_pol_t'(ctl_addr[0]);
      pin_en <= ctl_addr[1];
    end
  end

  // R2: a control write is latched from the address bits
  a_r2_ctl_latch: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (pin_en == $past(ctl_addr[1]) && pol == edge_pol_t'($past(ctl_addr[0]))));
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import pin_edge_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_pol_t pol,
  output logic      edge_evt
);
  localparam int FILL = SYNC_STAGES + 1;
  localparam int CW   = $clog2(FILL + 1);

  logic          prev;
  logic [CW-1:0] fill_cnt;
  logic          fill_done;
  logic          rise, fall;

  assign fill_done = (fill_cnt == CW'(FILL));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= 1'b0;
      fill_cnt <= '0;
    end else begin
      prev <= lvl;
      if (!fill_done) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    edge_evt = 1'b0;
    if (fill_done) begin
      case (pol)
        POL_RISE: edge_evt = rise;
        default:  edge_evt = fall;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int FLAG_W  = 8,
  parameter int TMR_BIT = 7,
  parameter int PIN_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_evt,
  input  logic              pin_en,
  input  logic              flag_rd,
  input  logic              tmr_flag,
  input  logic              tmr_en,
  output logic [FLAG_W-1:0] rd_data,
  output logic              irq_n
);
  logic              edge_flag;
  logic [FLAG_W-1:0] status;

  always_comb begin
    status          = '0;
    status[TMR_BIT] = tmr_flag;
    status[PIN_BIT] = edge_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_flag <= 1'b0;
      rd_data   <= '0;
      irq_n     <= 1'b1;
    end else begin
      if (edge_evt)     edge_flag <= 1'b1;
      else if (flag_rd) edge_flag <= 1'b0;
      if (flag_rd) rd_data <= status;
      irq_n <= ~((pin_en & edge_flag) | (tmr_en & tmr_flag));
    end
  end

  // R3: the flag only rises after a detected edge
  a_r3_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_flag) |-> $past(edge_evt));
  // R8: a detected edge always leaves the flag set, read or not
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> edge_flag);
  // R7: a read with no new edge clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !edge_evt) |=> !edge_flag);
  // R6: read data carries the pre-read flags
  a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
    flag_rd |=> (rd_data[PIN_BIT] == $past(edge_flag) && rd_data[TMR_BIT] == $past(tmr_flag)));
  // R9: enabled timer flag pulls the request low
  a_r9_timer_req: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && tmr_flag) |=> !irq_n);
  // R4: no enabled source keeps the request released
  a_r4_masked: assert property (@(posedge clk) disable iff (rst)
    (!pin_en && !(tmr_en && tmr_flag)) |=> irq_n);
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_W      = 8,
  parameter int TMR_BIT     = 7,
  parameter int PIN_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_addr,
  input  logic              flag_rd,
  input  logic              tmr_flag,
  input  logic              tmr_en,
  output logic [FLAG_W-1:0] rd_data,
  output logic              irq_n
);
  logic      pin_s;
  logic      edge_evt;
  logic      pin_en;
  edge_pol_t pol;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  irq_edge_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_addr (ctl_addr),
    .pol      (pol),
    .pin_en   (pin_en)
  );

  irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk      (clk),
    .rst      (rst),
    .lvl      (pin_s),
    .pol      (pol),
    .edge_evt (edge_evt)
  );

  irq_flag_reg #(
    .FLAG_W  (FLAG_W),
    .TMR_BIT (TMR_BIT),
    .PIN_BIT (PIN_BIT)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .edge_evt (edge_evt),
    .pin_en   (pin_en),
    .flag_rd  (flag_rd),
    .tmr_flag (tmr_flag),
    .tmr_en   (tmr_en),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
  );
endmodule

// File: tb/pin_edge_irq_test.sv
`timescale 1ns/1ps
module pin_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_in = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_addr = 2'b00;
  logic       flag_rd = 1'b0;
  logic       tmr_flag = 1'b0;
  logic       tmr_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_edge_irq uut (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .ctl_wr   (ctl_wr),
    .ctl_addr (ctl_addr),
    .flag_rd  (flag_rd),
    .tmr_flag (tmr_flag),
    .tmr_en   (tmr_en),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [1:0] a);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_addr = a;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_addr = 2'b00;
  endtask

  task automatic status_read(output logic [7:0] v);
    @(negedge clk);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic move_pin(input logic v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cycles(4);
    rst = 1'b0;
    chk("R1", "irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R1", "rd_data after reset", rd_data, 8'h00);
    cycles(8);
    status_read(v);
    chk("R10", "no flag from pin high through reset", v, 8'h00);
  endtask

  task automatic t_default_falling;
    logic [7:0] v;
    move_pin(1'b0);
    cycles(6);
    chk("R4", "irq_n with pin interrupt disabled", {7'd0, irq_n}, 8'h01);
    status_read(v);
    chk("R1", "falling edge selected after reset", v, 8'h40);
    status_read(v);
    chk("R7", "flag cleared by read", v, 8'h00);
  endtask

  task automatic t_rising_enabled;
    logic [7:0] v;
    ctl_write(2'b11);
    move_pin(1'b1);
    cycles(3);
    chk("R5", "irq_n before fourth edge", {7'd0, irq_n}, 8'h01);
    cycles(1);
    chk("R5", "irq_n on fourth edge", {7'd0, irq_n}, 8'h00);
    status_read(v);
    chk("R6", "status byte with pin flag", v, 8'h40);
    chk("R7", "irq_n on read edge", {7'd0, irq_n}, 8'h00);
    cycles(1);
    chk("R7", "irq_n released after read", {7'd0, irq_n}, 8'h01);
    cycles(3);
    chk("R6", "rd_data held between reads", rd_data, 8'h40);
    move_pin(1'b0);
    cycles(6);
    chk("R3", "opposite edge leaves irq_n high", {7'd0, irq_n}, 8'h01);
    status_read(v);
    chk("R3", "opposite edge leaves flag clear", v, 8'h00);
  endtask

  task automatic t_falling_enabled;
    logic [7:0] v;
    ctl_write(2'b10);
    move_pin(1'b1);
    cycles(6);
    chk("R2", "rising edge ignored in falling mode", {7'd0, irq_n}, 8'h01);
    move_pin(1'b0);
    cycles(4);
    chk("R2", "falling edge raises request", {7'd0, irq_n}, 8'h00);
    status_read(v);
    chk("R2", "falling mode flag", v, 8'h40);
  endtask

  task automatic t_rising_disabled;
    logic [7:0] v;
    ctl_write(2'b01);
    move_pin(1'b1);
    cycles(6);
    chk("R4", "disabled pin keeps irq_n high", {7'd0, irq_n}, 8'h01);
    status_read(v);
    chk("R4", "flag set while disabled", v, 8'h40);
  endtask

  task automatic t_timer;
    logic [7:0] v;
    tmr_flag = 1'b1;
    cycles(3);
    chk("R9", "timer flag masked", {7'd0, irq_n}, 8'h01);
    status_read(v);
    chk("R9", "timer bit in status", v, 8'h80);
    status_read(v);
    chk("R7", "read leaves timer flag", v, 8'h80);
    @(negedge clk);
    tmr_en = 1'b1;
    cycles(1);
    chk("R9", "enabled timer pulls irq_n", {7'd0, irq_n}, 8'h00);
    tmr_flag = 1'b0;
    cycles(1);
    chk("R9", "timer release", {7'd0, irq_n}, 8'h01);
    tmr_en = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] v;
    ctl_write(2'b11);
    move_pin(1'b0);
    cycles(6);
    status_read(v);
    move_pin(1'b1);
    cycles(2);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    chk("R8", "read colliding with edge returns old flag", rd_data, 8'h00);
    cycles(1);
    chk("R8", "flag survives colliding read", {7'd0, irq_n}, 8'h00);
    status_read(v);
    chk("R8", "flag visible on next read", v, 8'h40);
  endtask

  initial begin
    t_reset();
    t_default_falling();
    t_rising_enabled();
    t_falling_enabled();
    t_rising_disabled();
    t_timer();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule